// File: doc/BRIEF.md
# Multi-lane SPI master

This block drives one SPI bus as master. After a single-cycle start request it pulls an active-low chip select, runs a serial clock, and shifts one to four data lanes in parallel. All lanes share the clock and the select line, and each lane carries its own stream of words. A whole burst of up to 127 words per lane runs under one chip-select assertion. The burst is framed by a lead time before the first clock edge and a lag time after the last edge, both counted in whole SPI clock periods.

Software or a neighbouring engine fills a transmit buffer, indexed by lane and word, before it raises the start request. It then waits for the done pulse and reads the received words from a receive buffer with the same indexing. The clock mode, word length, bit order, lane count, word count, half-period length and the two framing delays are plain inputs. They are sampled on the edge that accepts the start request and are held internally for the rest of the transfer.

Top module: `spi_lane_master`

## Requirements
- R1: `cs_n` is high whenever the block is idle. A start request seen while idle is accepted on that clock edge. From that edge `cs_n` is low and `busy` is high, and the configuration inputs are captured there.
- R2: The first `sclk` edge comes exactly 2·L·H cycles after `cs_n` falls. L is `lead_per` (0 counts as 1) and H is `half_ticks` (0 counts as 1).
- R3: Each clock phase lasts H cycles. A transfer has exactly 2·B clock edges, where B = W·(16 if `wide` else 8) and W is `words` (0 counts as 1).
- R4: `sclk` rests at the polarity bit. While idle it follows the `cpol` input. During a transfer it starts and ends at the captured value.
- R5: Edges are counted from 0. With `cpha`=0, MISO is captured on even edges (rising for `cpol`=0, falling for `cpol`=1). With `cpha`=1, MISO is captured on odd edges (falling for `cpol`=0, rising for `cpol`=1).
- R6: With `cpha`=0, the first bit is on MOSI from the moment `cs_n` falls, the bit changes on odd edges, and MOSI is 0 after the last edge. With `cpha`=1, MOSI is 0 until edge 0, the bit changes on even edges, and the last bit is held until release.
- R7: Lane l sends transmit words at addresses 0 to W-1, in that order. In 8-bit mode only bits 7..0 of each word are sent. `lsb_first`=1 sends bit 0 first; otherwise the top bit of the word length goes first. Receive words use the same ordering.
- R8: Lanes 0 to `lane_sel` are active. Inactive lanes hold MOSI at 0, ignore MISO, and leave their receive words unchanged.
- R9: `cs_n` rises exactly 2·G·H cycles after the last clock edge, where G is `lag_per` (0 counts as 1).
- R10: `done` is high for exactly one cycle, the cycle in which `cs_n` returns high. `busy` falls on the following cycle.
- R11: A start request while `busy` is high, including the `done` cycle, has no effect on the bus or on the buffers.
- R12: The word received on lane l as word k is readable at `rx_lane`=l, `rx_addr`=k. In 8-bit mode bits 15..8 of that word read 0.
- R13: After reset `cs_n`=1, `busy`=0, `done`=0, MOSI is all 0, and every receive word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted only while idle |
| cpol | input | 1 | Clock rest level |
| cpha | input | 1 | 0: capture on even edges, 1: capture on odd edges |
| wide | input | 1 | 1: 16-bit words, 0: 8-bit words |
| lsb_first | input | 1 | 1: bit 0 first |
| lane_sel | input | LW | Number of active lanes minus one |
| words | input | AW | Words per lane per transfer (0 treated as 1) |
| half_ticks | input | DIV_W | Clock phase length in cycles (0 treated as 1) |
| lead_per | input | DLY_W | Whole periods from select to first edge (0 treated as 1) |
| lag_per | input | DLY_W | Whole periods from last edge to release (0 treated as 1) |
| tx_we | input | 1 | Transmit buffer write strobe |
| tx_lane | input | LW | Transmit buffer lane |
| tx_addr | input | AW | Transmit buffer word address |
| tx_wdata | input | 16 | Transmit buffer write data |
| rx_lane | input | LW | Receive buffer lane to read |
| rx_addr | input | AW | Receive buffer word to read |
| rx_rdata | output | 16 | Receive buffer read data (combinational) |
| miso | input | LANES | Serial data in, one bit per lane |
| mosi | output | LANES | Serial data out, one bit per lane |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Take the edge that accepts a start request as cycle 0. Then `cs_n` and `busy` change right after cycle 0, and clock edge e is due after cycle (2L+e)·H. Release and `done` are due after cycle (2L+2B-1+2G)·H, and `busy` clears one cycle later. MISO is captured on the rising clock edge at exactly those edge times. A timeline model in the bench computes the expected level of every output from the cycle offset alone. It samples all outputs 1 ns after each falling edge, so every register on the path has settled. The receive buffer is read only after `busy` has dropped, and at that point each captured word is final.

// File: rtl/spi_lane_master.sv
module spi_lane_master #(
  parameter int LANES = 4,
  parameter int AW    = 7,
  parameter int DIV_W = 8,
  parameter int DLY_W = 4,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             wide,
  input  logic             lsb_first,
  input  logic [LW-1:0]    lane_sel,
  input  logic [AW-1:0]    words,
  input  logic [DIV_W-1:0] half_ticks,
  input  logic [DLY_W-1:0] lead_per,
  input  logic [DLY_W-1:0] lag_per,
  input  logic             tx_we,
  input  logic [LW-1:0]    tx_lane,
  input  logic [AW-1:0]    tx_addr,
  input  logic [15:0]      tx_wdata,
  input  logic [LW-1:0]    rx_lane,
  input  logic [AW-1:0]    rx_addr,
  output logic [15:0]      rx_rdata,
  input  logic [LANES-1:0] miso,
  output logic [LANES-1:0] mosi,
  output logic             sclk,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = AW + 4;
  localparam int NW    = AW + 5;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_LAG, S_FIN} st_t;

  st_t              st;
  logic [DIV_W-1:0] tick, c_h;
  logic [DLY_W:0]   hcnt, c_lead2, c_lag2;
  logic [NW-1:0]    n, c_last;
  logic             c_cpol, c_cpha, c_wide, c_lsb;
  logic [LANES-1:0] c_mask, act_mask;
  logic             sclk_q, cs_q;
  logic [15:0]      tx_mem [LANES][DEPTH];
  logic [15:0]      rx_mem [LANES][DEPTH];

  function automatic logic [AW-1:0] waddr(input logic [BW-1:0] b, input logic w16);
    return w16 ? AW'(b >> 4) : AW'(b >> 3);
  endfunction

  function automatic logic [3:0] bpos(input logic [BW-1:0] b, input logic w16);
    return w16 ? b[3:0] : {1'b0, b[2:0]};
  endfunction

  function automatic logic [3:0] bsel(input logic [BW-1:0] b, input logic w16, input logic lsb);
    return lsb ? bpos(b, w16) : (w16 ? 4'd15 : 4'd7) - bpos(b, w16);
  endfunction

  // start-time configuration
  logic [AW-1:0]    w_eff;
  logic [DIV_W-1:0] h_eff;
  logic [DLY_W-1:0] ld_eff, lg_eff;
  assign w_eff  = (words == '0) ? AW'(1) : words;
  assign h_eff  = (half_ticks == '0) ? DIV_W'(1) : half_ticks;
  assign ld_eff = (lead_per == '0) ? DLY_W'(1) : lead_per;
  assign lg_eff = (lag_per == '0) ? DLY_W'(1) : lag_per;

  always_comb begin
    for (int l = 0; l < LANES; l++) act_mask[l] = (l <= int'(lane_sel));
  end

  // timing
  logic h_end, lead_done, edge_ev;
  assign h_end     = (tick == c_h - 1'b1);
  assign lead_done = (st == S_LEAD) && h_end && (hcnt == c_lead2);
  assign edge_ev   = lead_done || ((st == S_SHIFT) && h_end);

  // transmit side
  logic [NW-1:0] nb;
  logic [BW-1:0] m_bit;
  logic [AW-1:0] m_addr;
  logic [3:0]    m_sel;
  logic          mosi_on;
  assign nb      = c_cpha ? n - 1'b1 : n;
  assign m_bit   = BW'(nb >> 1);
  assign m_addr  = waddr(m_bit, c_wide);
  assign m_sel   = bsel(m_bit, c_wide, c_lsb);
  assign mosi_on = (st == S_LEAD || st == S_SHIFT || st == S_LAG) &&
                   (c_cpha ? (n != '0) : (n <= c_last));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mosi[g] = mosi_on & c_mask[g] & tx_mem[g][m_addr][m_sel];
  end

  // receive side
  logic [BW-1:0] s_bit;
  logic [AW-1:0] s_addr;
  logic [3:0]    s_sel;
  logic          s_first, s_now;
  assign s_bit   = BW'(n >> 1);
  assign s_addr  = waddr(s_bit, c_wide);
  assign s_sel   = bsel(s_bit, c_wide, c_lsb);
  assign s_first = (bpos(s_bit, c_wide) == 4'd0);
  assign s_now   = edge_ev && (n[0] == c_cpha);

  always_ff @(posedge clk) begin
    if (tx_we) tx_mem[tx_lane][tx_addr] <= tx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++)
        for (int a = 0; a < DEPTH; a++) rx_mem[l][a] <= '0;
    end else if (s_now) begin
      for (int l = 0; l < LANES; l++) begin
        if (c_mask[l]) begin
          if (s_first) rx_mem[l][s_addr] <= 16'(miso[l]) << s_sel;
          else         rx_mem[l][s_addr][s_sel] <= miso[l];
        end
      end
    end
  end

  assign rx_rdata = rx_mem[rx_lane][rx_addr];

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      tick    <= '0;
      hcnt    <= '0;
      n       <= '0;
      c_h     <= DIV_W'(1);
      c_lead2 <= '0;
      c_lag2  <= '0;
      c_last  <= '0;
      c_cpol  <= 1'b0;
      c_cpha  <= 1'b0;
      c_wide  <= 1'b0;
      c_lsb   <= 1'b0;
      c_mask  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          c_h     <= h_eff;
          c_lead2 <= (DLY_W+1)'({ld_eff, 1'b0} - 1);
          c_lag2  <= (DLY_W+1)'({lg_eff, 1'b0} - 1);
          c_last  <= NW'((32'(w_eff) << (wide ? 5 : 4)) - 32'd1);
          c_cpol  <= cpol;
          c_cpha  <= cpha;
          c_wide  <= wide;
          c_lsb   <= lsb_first;
          c_mask  <= act_mask;
          sclk_q  <= cpol;
          cs_q    <= 1'b0;
          tick    <= '0;
          hcnt    <= '0;
          n       <= '0;
          st      <= S_LEAD;
        end
        S_LEAD: begin
          tick <= h_end ? '0 : tick + 1'b1;
          if (h_end) begin
            if (hcnt == c_lead2) begin
              sclk_q <= ~sclk_q;
              n      <= n + 1'b1;
              st     <= S_SHIFT;
            end else hcnt <= hcnt + 1'b1;
          end
        end
        S_SHIFT: begin
          tick <= h_end ? '0 : tick + 1'b1;
          if (h_end) begin
            sclk_q <= ~sclk_q;
            n      <= n + 1'b1;
            if (n == c_last) begin
              hcnt <= '0;
              st   <= S_LAG;
            end
          end
        end
        S_LAG: begin
          tick <= h_end ? '0 : tick + 1'b1;
          if (h_end) begin
            if (hcnt == c_lag2) begin
              cs_q <= 1'b1;
              st   <= S_FIN;
            end else hcnt <= hcnt + 1'b1;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sclk = (st == S_IDLE) ? cpol : sclk_q;
  assign cs_n = cs_q;
  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);
endmodule

module spi_lane_master_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             cs_n,
  input logic             sclk,
  input logic             c_cpol,
  input logic [LANES-1:0] mosi
);
  AST_CS_HIGH_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);               // R1
  AST_SELECT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> $past(!busy)); // R11
  AST_DONE_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);               // R10
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(cs_n));         // R10
  AST_MOSI_QUIET:      assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> (mosi == '0));        // R8
  AST_SCLK_REST:       assert property (@(posedge clk) disable iff (!rst_n) (busy && cs_n) |-> (sclk == c_cpol)); // R4
endmodule

bind spi_lane_master spi_lane_master_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cs_n(cs_n),
  .sclk(sclk), .c_cpol(c_cpol), .mosi(mosi)
);

// File: tb/spi_lane_master_tb.sv
`timescale 1ns/1ps
module spi_lane_master_tb;
  localparam int LANES = 4;
  localparam int DEPTH = 128;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        cpol = 1'b0, cpha = 1'b0, wide = 1'b0, lsb_first = 1'b0;
  logic [1:0]  lane_sel = '0;
  logic [6:0]  words = '0;
  logic [7:0]  half_ticks = 8'd1;
  logic [3:0]  lead_per = 4'd1, lag_per = 4'd1;
  logic        tx_we = 1'b0;
  logic [1:0]  tx_lane = '0, rx_lane = '0;
  logic [6:0]  tx_addr = '0, rx_addr = '0;
  logic [15:0] tx_wdata = '0, rx_rdata;
  logic [3:0]  miso = '0, mosi;
  logic        sclk, cs_n, busy, done;

  always #2 clk = ~clk;

  spi_lane_master u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
    .wide(wide), .lsb_first(lsb_first), .lane_sel(lane_sel), .words(words),
    .half_ticks(half_ticks), .lead_per(lead_per), .lag_per(lag_per),
    .tx_we(tx_we), .tx_lane(tx_lane), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
    .rx_lane(rx_lane), .rx_addr(rx_addr), .rx_rdata(rx_rdata),
    .miso(miso), .mosi(mosi), .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;
  bit cmp_en = 1'b0;

  // timeline model
  int cyc = 0, t0 = 0, tcs = 0;
  bit active = 1'b0;
  int mL, mG, mH, mB, mWb, mlanes;
  bit mcpol, mcpha, mlsb;
  logic [15:0] txm [LANES][DEPTH];
  logic [15:0] rxm [LANES][DEPTH];

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", what, cyc, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int edges_done(int d);
    int lh = 2 * mL * mH;
    int r;
    if (d < lh) return 0;
    r = (d - lh) / mH + 1;
    return (r > 2 * mB) ? 2 * mB : r;
  endfunction

  function automatic logic [3:0] exp_mosi(int ne);
    logic [3:0] r = '0;
    int bi, w, pos, idx;
    if (mcpha) begin
      if (ne == 0) return '0;
      bi = (ne - 1) / 2;
    end else begin
      if (ne >= 2 * mB) return '0;
      bi = ne / 2;
    end
    w = bi / mWb;
    pos = bi % mWb;
    idx = mlsb ? pos : mWb - 1 - pos;
    for (int l = 0; l < mlanes; l++) r[l] = txm[l][w][idx];
    return r;
  endfunction

  always @(posedge clk) begin
    int d, lh, e, bi, w, pos, idx;
    if (!rst_n) active = 1'b0;
    else begin
      cyc = cyc + 1;
      if (active) begin
        d = cyc - t0;
        lh = 2 * mL * mH;
        if (d >= lh && ((d - lh) % mH) == 0) begin
          e = (d - lh) / mH;
          if (e < 2 * mB && (e % 2) == int'(mcpha)) begin
            bi = e / 2;
            w = bi / mWb;
            pos = bi % mWb;
            idx = mlsb ? pos : mWb - 1 - pos;
            for (int l = 0; l < mlanes; l++) begin
              if (pos == 0) rxm[l][w] = 16'(miso[l]) << idx;
              else rxm[l][w][idx] = miso[l];
            end
          end
        end
      end
      if (start && !(active && (cyc - 1 - t0) <= tcs)) begin
        t0 = cyc;
        active = 1'b1;
        mcpol = cpol; mcpha = cpha; mlsb = lsb_first;
        mL = (lead_per == 0) ? 1 : int'(lead_per);
        mG = (lag_per == 0) ? 1 : int'(lag_per);
        mH = (half_ticks == 0) ? 1 : int'(half_ticks);
        mWb = wide ? 16 : 8;
        mB = ((words == 0) ? 1 : int'(words)) * mWb;
        mlanes = int'(lane_sel) + 1;
        tcs = (2 * mL + 2 * mB - 1 + 2 * mG) * mH;
      end
    end
  end

  always @(negedge clk) miso = 4'($urandom);

  always @(negedge clk) begin
    int d, ne;
    bit eb, ec, ed, es;
    #1;
    if (cmp_en) begin
      d  = cyc - t0;
      eb = active && d <= tcs;
      ec = !(active && d < tcs);
      ed = active && d == tcs;
      ne = (active && d < tcs) ? edges_done(d) : 0;
      es = eb ? (mcpol ^ ne[0]) : cpol;
      chk(cs_n == ec, "R1 R9 cs_n", 32'(cs_n), 32'(ec));
      chk(busy == eb, "R1 R11 busy", 32'(busy), 32'(eb));
      chk(done == ed, "R10 done", 32'(done), 32'(ed));
      chk(sclk == es, "R2 R3 R4 sclk", 32'(sclk), 32'(es));
      chk(mosi == (ec ? 4'b0 : exp_mosi(ne)), "R6 R7 R8 mosi", 32'(mosi),
          32'(ec ? 4'b0 : exp_mosi(ne)));
    end
  end

  task automatic load_tx();
    for (int l = 0; l < LANES; l++)
      for (int a = 0; a < DEPTH; a++) begin
        @(negedge clk);
        tx_we = 1'b1; tx_lane = 2'(l); tx_addr = 7'(a);
        tx_wdata = 16'($urandom);
        txm[l][a] = tx_wdata;
      end
    @(negedge clk);
    tx_we = 1'b0;
  endtask

  task automatic check_rx(input string tag);
    for (int l = 0; l < LANES; l++)
      for (int a = 0; a < DEPTH; a++) begin
        @(negedge clk);
        rx_lane = 2'(l); rx_addr = 7'(a);
        #1;
        chk(rx_rdata == rxm[l][a], tag, 32'(rx_rdata), 32'(rxm[l][a]));
      end
  endtask

  task automatic run_case(input logic cp, input logic ph, input logic wd, input logic lf,
                          input logic [1:0] ls, input logic [6:0] wn, input logic [7:0] ht,
                          input logic [3:0] ld, input logic [3:0] lg, input bit poke);
    load_tx();
    @(negedge clk);
    cpol = cp; cpha = ph; wide = wd; lsb_first = lf; lane_sel = ls;
    words = wn; half_ticks = ht; lead_per = ld; lag_per = lg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check_rx("R5 R7 R8 R12 rx word");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  initial begin
    for (int l = 0; l < LANES; l++)
      for (int a = 0; a < DEPTH; a++) rxm[l][a] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n == 1'b1, "R13 cs_n in reset", 32'(cs_n), 32'd1);
    chk(busy == 1'b0, "R13 busy in reset", 32'(busy), 32'd0);
    chk(done == 1'b0, "R13 done in reset", 32'(done), 32'd0);
    chk(mosi == 4'b0, "R13 mosi in reset", 32'(mosi), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    check_rx("R13 rx after reset");
    // mode 0, 8-bit, MSB first, one lane
    run_case(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 7'd2, 8'd2, 4'd1, 4'd1, 1'b0);
    // mode 1, 16-bit, LSB first, four lanes, ignored second start (R11)
    run_case(1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 7'd3, 8'd3, 4'd2, 4'd3, 1'b1);
    // mode 2, 8-bit, LSB first, two lanes, zero settings read as one
    run_case(1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 7'd1, 8'd0, 4'd0, 4'd0, 1'b0);
    // mode 3, 16-bit, MSB first, three lanes
    run_case(1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 7'd4, 8'd1, 4'd3, 4'd2, 1'b1);
    // zero word count counts as one word (R3)
    run_case(1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 7'd0, 8'd5, 4'd1, 4'd2, 1'b0);
    // longest burst, 127 words per lane
    run_case(1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 7'd127, 8'd1, 4'd1, 4'd1, 1'b0);
    repeat (4) @(negedge clk);
    report();
  end
endmodule